// File: doc/BRIEF.md
# Colour-Space Coefficient Float Encoder

This block turns one signed fixed-point coefficient into the compact packed code that a video colour-space converter keeps in its coefficient registers. The coefficient arrives on `coefIn` as a two's-complement number with `IntBits` integer bits and `FracBits` fraction bits. The defaults give a Q3.16 value, 20 bits wide, covering [-8, 8). A two-bit format select picks one of four packings. The first is a plain unsigned 1.9 fixed-point field. The second and third are floating-style fields with a short exponent over a 9-bit mantissa. The fourth is an 8-bit gain code used for saturation and contrast.

Only the magnitude is encoded. The block finds the magnitude, normalises it, rounds it to nearest and saturates it in a single clock. The result is captured into an output register when `validIn` is high. One cycle after the strobe, `validOut` pulses and the code appears on `codeOut`. The code then stays on `codeOut` until the next strobe. Codes narrower than 12 bits are right-aligned, and the unused upper bits are zero.

Top module: `csc_coef_encoder`

## Requirements
- R1: `validOut` is high in exactly the cycle after each cycle in which `validIn` is sampled high, and low otherwise.
- R2: When no strobe is sampled, `codeOut` keeps its previous value.
- R3: The sign of `coefIn` has no effect. A negative input gives the same code as its absolute value.
- R4: Format 0 (fixed 1.9) produces round(|x|·512), clamped to 0x3FF.
- R5: Formats 1 and 2 with |x| < 1.0 double the value while it is below 0.5, at most three times. The number of doublings is the exponent, placed directly above the 9-bit mantissa at bits [10:9] in format 1 and [11:9] in format 2.
- R6: In formats 1 and 2 the mantissa is floor(normalised·512 + 0.5). A result of 512 or more saturates to 511.
- R7: Format 1 with |x| ≥ 1.0 produces exponent 0 with mantissa 511, which is code 0x1FF.
- R8: Format 2 with |x| ≥ 1.0 produces exponent 7 with mantissa 0x100, which is code 0xF00.
- R9: Format 2 never produces exponent values 4, 5 or 6.
- R10: Format 3 (gain) puts a 2-bit code c in bits [7:6] and a 6-bit mantissa in bits [5:0], where the mantissa is round(|x|·2^(6−c)). The code c is the smallest one for which the rounded mantissa is at most 63.
- R11: Format 3 with no code that fits produces c = 3 and mantissa 63, which is code 0xFF.
- R12: During reset `validOut` is 0 and `codeOut` is 0.
- R13: Bits of `codeOut` above the selected field's width are zero (bit 11 and up for format 1, bit 10 and up for format 0, bit 8 and up for format 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Capture strobe for `coefIn` and `fmtSel` |
| fmtSel | input | 2 | 0 = fixed 1.9, 1 = 11-bit float, 2 = 12-bit float, 3 = 8-bit gain |
| coefIn | input | IntBits+FracBits+1 (20) | Signed fixed-point coefficient |
| validOut | output | 1 | One-cycle pulse marking a new code |
| codeOut | output | 12 | Packed code, right-aligned and held |

## Verification
Two things can happen in the same cycle: a new capture, and the presentation of the previous result, which R1 and R2 both rest on. The bench provokes this with back-to-back strobes that switch format on every cycle. Every strobe is stamped with its cycle number, and the scoreboard requires each result to appear exactly one cycle later with the value of its own strobe. Idle gaps between bursts test that the code register is held and that the valid pulse falls.

// File: rtl/csc_coef_pkg.sv
package csc_coef_pkg;

  localparam int CodeW = 12;

  typedef enum logic [1:0] {
    FMT_FIX10 = 2'd0,
    FMT_EXP11 = 2'd1,
    FMT_EXP12 = 2'd2,
    FMT_GAIN8 = 2'd3
  } fmtSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selFix;
    logic selE11;
    logic selE12;
    logic selGain;
  } encStrobe_t;

endpackage

// File: rtl/csc_coef_mag.sv
module csc_coef_mag #(
  parameter int IntBits  = 3,
  parameter int FracBits = 16,
  localparam int InW     = IntBits + FracBits + 1
) (
  input  logic [InW-1:0] coefIn,
  output logic [InW-1:0] magOut
);
  logic negIn;
  assign negIn = coefIn[InW-1];

  // the most negative input negates to 2^(InW-1), which still fits as unsigned
  always_comb begin
    if (negIn) magOut = (~coefIn) + InW'(1);
    else       magOut = coefIn;
  end
endmodule

// File: rtl/csc_coef_ctrl.sv
module csc_coef_ctrl
  import csc_coef_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [1:0] fmtSel,
  output encStrobe_t strobe,
  output logic       validOut
);
  fmtSel_e fmtDec;
  assign fmtDec = fmtSel_e'(fmtSel);

  always_comb begin
    strobe.load    = validIn;
    strobe.selFix  = validIn && (fmtDec == FMT_FIX10);
    strobe.selE11  = validIn && (fmtDec == FMT_EXP11);
    strobe.selE12  = validIn && (fmtDec == FMT_EXP12);
    strobe.selGain = validIn && (fmtDec == FMT_GAIN8);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
endmodule

// File: rtl/csc_coef_pack.sv
module csc_coef_pack
  import csc_coef_pkg::*;
#(
  parameter int IntBits  = 3,
  parameter int FracBits = 16,
  localparam int MagW    = IntBits + FracBits + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  encStrobe_t       strobe,
  input  logic [MagW-1:0]  mag,
  output logic [CodeW-1:0] code
);
  localparam int SumW      = MagW + 1;
  localparam int FixW      = 10;
  localparam int FixFrac   = 9;
  localparam int FixShift  = FracBits - FixFrac;
  localparam int MantW     = 9;
  localparam int MantShift = FracBits - MantW;
  localparam int GainMantW = 6;
  localparam int GainCodes = 4;
  localparam logic [FixW-1:0]      FixAllOnes  = '1;
  localparam logic [MantW-1:0]     MantAllOnes = '1;
  localparam logic [MantW-1:0]     UnityMant   = MantW'(1 << (MantW - 1));
  localparam logic [GainMantW-1:0] GainAllOnes = '1;

  // ---------------- fixed 1.9 ----------------
  logic [SumW-1:0] fixSum, fixQ;
  logic [FixW-1:0] fixCode;
  assign fixSum  = SumW'(mag) + (SumW'(1) << (FixShift - 1));
  assign fixQ    = fixSum >> FixShift;
  assign fixCode = (fixQ > SumW'(FixAllOnes)) ? FixAllOnes : fixQ[FixW-1:0];

  // ---------------- normalised exponent/mantissa ----------------
  logic                belowOne;
  logic [FracBits-1:0] fracPart, normFrac;
  logic [1:0]          normExp;
  logic [FracBits:0]   mantSum, mantQ;
  logic [MantW-1:0]    mant;

  assign belowOne = (mag[MagW-1:FracBits] == '0);
  assign fracPart = mag[FracBits-1:0];

  // bounded doubling: count leading zero fraction bits, at most three
  always_comb begin
    if (fracPart[FracBits-1])      normExp = 2'd0;
    else if (fracPart[FracBits-2]) normExp = 2'd1;
    else if (fracPart[FracBits-3]) normExp = 2'd2;
    else                           normExp = 2'd3;
  end

  assign normFrac = fracPart << normExp;
  assign mantSum  = {1'b0, normFrac} + ((FracBits+1)'(1) << (MantShift - 1));
  assign mantQ    = mantSum >> MantShift;
  assign mant     = (mantQ > (FracBits+1)'(MantAllOnes)) ? MantAllOnes : mantQ[MantW-1:0];

  logic [10:0] e11Code;
  logic [11:0] e12Code;
  assign e11Code = belowOne ? {normExp, mant} : {2'b00, MantAllOnes};
  assign e12Code = belowOne ? {1'b0, normExp, mant} : {3'b111, UnityMant};

  // ---------------- 8-bit gain ----------------
  logic [GainMantW-1:0] gainMant [GainCodes];
  logic [GainCodes-1:0] gainFits;

  for (genvar c = 0; c < GainCodes; c++) begin : g_gainRange
    localparam int Sh = FracBits - GainMantW + c;
    logic [SumW-1:0] rSum, rQ;
    assign rSum        = SumW'(mag) + (SumW'(1) << (Sh - 1));
    assign rQ          = rSum >> Sh;
    assign gainFits[c] = (rQ <= SumW'(GainAllOnes));
    assign gainMant[c] = rQ[GainMantW-1:0];
  end

  logic [7:0] gainCode;
  always_comb begin
    gainCode = {2'b11, GainAllOnes};
    for (int c = GainCodes - 1; c >= 0; c--) begin
      if (gainFits[c]) gainCode = {2'(c), gainMant[c]};
    end
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code <= '0;
    end else if (strobe.load) begin
      if (strobe.selFix)      code <= CodeW'(fixCode);
      else if (strobe.selE11) code <= CodeW'(e11Code);
      else if (strobe.selE12) code <= e12Code;
      else                    code <= CodeW'(gainCode);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(code));
  p_unity_e11_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selE11 && mag >= MagW'(1 << FracBits)) |=> code == 12'h1FF);
  p_unity_e12_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selE12 && mag >= MagW'(1 << FracBits)) |=> code == 12'hF00);
  p_no_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selE12 |=> (code[11:9] <= 3'd3 || code[11:9] == 3'd7));
  p_narrow_gain_r13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selGain |=> code[11:8] == 4'd0);
  p_narrow_fix_r13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selFix |=> code[11:10] == 2'd0);
endmodule

// File: rtl/csc_coef_encoder.sv
module csc_coef_encoder
  import csc_coef_pkg::*;
#(
  parameter int IntBits  = 3,
  parameter int FracBits = 16,
  localparam int InW     = IntBits + FracBits + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [1:0]       fmtSel,
  input  logic [InW-1:0]   coefIn,
  output logic             validOut,
  output logic [CodeW-1:0] codeOut
);
  encStrobe_t     strobe;
  logic [InW-1:0] magVal;

  csc_coef_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .fmtSel   (fmtSel),
    .strobe   (strobe),
    .validOut (validOut)
  );

  csc_coef_mag #(.IntBits(IntBits), .FracBits(FracBits)) u_mag (
    .coefIn (coefIn),
    .magOut (magVal)
  );

  csc_coef_pack #(.IntBits(IntBits), .FracBits(FracBits)) u_pack (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .mag    (magVal),
    .code   (codeOut)
  );
endmodule

// File: tb/csc_coef_encoder_test.sv
module csc_coef_encoder_test;
  localparam int IntBits  = 3;
  localparam int FracBits = 16;
  localparam int InW      = IntBits + FracBits + 1;
  localparam longint One  = 65536;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           validIn = 1'b0;
  logic [1:0]     fmtSel = 2'd0;
  logic [InW-1:0] coefIn = '0;
  logic           validOut;
  logic [11:0]    codeOut;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  logic [11:0] expQ   [$];
  string       reqQ   [$];
  int          stampQ [$];
  logic [11:0] lastExp = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  csc_coef_encoder uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .fmtSel(fmtSel),
    .coefIn(coefIn), .validOut(validOut), .codeOut(codeOut)
  );

  function automatic logic [11:0] model(int fmt, longint x);
    longint m, q, v, mant;
    int e;
    m = (x < 0) ? -x : x;
    case (fmt)
      0: begin
        q = (m + 64) >> 7;
        if (q > 1023) q = 1023;
        return 12'(q);
      end
      1, 2: begin
        if (m >= One) return (fmt == 1) ? 12'h1FF : 12'hF00;
        e = 0; v = m;
        while (e < 3 && v < 32768) begin v = v * 2; e++; end
        mant = (v + 64) >> 7;
        if (mant > 511) mant = 511;
        return 12'(e * 512 + mant);
      end
      default: begin
        for (int c = 0; c < 4; c++) begin
          q = (m + (longint'(1) << (9 + c))) >> (10 + c);
          if (q <= 63) return 12'(c * 64 + q);
        end
        return 12'h0FF;
      end
    endcase
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one strobe, expectation pushed to the scoreboard
  task automatic send(int fmt, longint x, string req);
    @(negedge clk);
    validIn = 1'b1;
    fmtSel  = 2'(fmt);
    coefIn  = InW'(x);
    lastExp = model(fmt, x);
    expQ.push_back(lastExp);
    reqQ.push_back(req);
    stampQ.push_back(cycle);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    validIn = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: pops and compares results, including their timing (R1)
  always @(negedge clk) begin
    if (rstN && validOut) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 actual=valid expected=no result pending");
      end else begin
        logic [11:0] e;
        string r;
        int st;
        e = expQ.pop_front(); r = reqQ.pop_front(); st = stampQ.pop_front();
        check(r, codeOut, e);
        checks++;
        if (cycle != st + 1) begin
          fails++;
          $display("FAIL R1 actual=cycle %0d expected=cycle %0d", cycle, st + 1);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 code", codeOut, 12'h000);
    check("R12 valid", {11'd0, validOut}, 12'h000);
    rstN = 1'b1;
    @(negedge clk);

    // R4 fixed 1.9
    send(0, 32768, "R4 half");
    send(0, 63, "R4 round down");
    send(0, 64, "R4 round up");
    send(0, 2 * One, "R4 clamp");
    send(0, -16384, "R3 R4 negative");
    idle(3);

    // R5 R6 R7 11-bit
    send(1, 49152, "R5 no doubling");
    send(1, 13107, "R5 two doublings");
    send(1, 655, "R5 three doublings");
    send(1, 65500, "R6 mantissa saturation");
    send(1, 3 * One / 2, "R7 unity saturation");
    send(1, -49152, "R3 negative e11");
    idle(2);

    // R8 R9 12-bit
    send(2, One, "R8 exact one");
    send(2, -3 * One, "R8 R3 negative large");
    send(2, 13107, "R9 R5 small e12");
    send(2, 655, "R9 three doublings e12");
    send(2, 1, "R9 tiny");
    idle(2);

    // R10 R11 gain
    send(3, 32768, "R10 code 0");
    send(3, 98304, "R10 code 1");
    send(3, 5 * One, "R10 code 2 to 3");
    send(3, 65024, "R10 rounding carry");
    send(3, -8 * One, "R11 clamp");
    send(3, 8 * One - 1, "R11 near top");
    idle(2);

    // back-to-back with format switches (R1, R13)
    for (int i = 0; i < 16; i++) send(i % 4, (i * 37123) - 250000, "R13 R1 burst");
    idle(4);

    // R2 hold across idle cycles
    for (int i = 0; i < 3; i++) begin
      check("R2 hold", codeOut, lastExp);
      check("R1 idle valid", {11'd0, validOut}, 12'h000);
      @(negedge clk);
    end

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1 actual=%0d pending expected=0", expQ.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule